// File: doc/BRIEF.md
# Endpoint FIFO Access Handshake Controller

This block sits between a local processor's register bus and a set of per-endpoint byte FIFOs that a USB serial engine also uses. The processor never touches a FIFO directly. It first writes a control word naming an endpoint and a direction, with a request bit set. It then polls the same control register until a ready bit appears, and only then moves one byte through that endpoint's data register. Each byte moved restarts a settle window of `GAP` clock cycles. A data access made inside that window, to the wrong endpoint, in the wrong direction, or while not ready is dropped, and a sticky error bit is set.

The host side owns whichever pipe it flags as active. While that pipe is the one the processor has selected, ready is held low and the settle window is held at its start. When the host signals that a transaction is done, the block raises a one-cycle interrupt and latches the pipe number on an active-pipe output. The processor can also ask for a zero-length packet on an endpoint. It raises a request with the zero-length bit set, waits for ready, and then drops the request. This leaves a pending flag for the serial engine, which is cleared when the host completes that pipe.

Top module: `epfifo_access_ctrl`

## Requirements
- R1: After reset, the control register reads 00h, `usb_irq` is 0, `act_pipe` is 0 and every `zlp_flags` bit is 0.
- R2: The control word has these fields: bit 0 is the request, bit 1 is the direction (1 = processor writes), bit 2 is the zero-length command, bits 5:4 are the endpoint, bit 6 reads as ready and bit 7 reads as the error flag. Ready reads 1 exactly `GAP` clock edges after a control write that sets the request, provided that no other condition holds it low.
- R3: An accepted read of data register `DATA_BASE+ep` returns that FIFO's bytes in arrival order and removes each byte. An accepted write appends the byte.
- R4: An accepted data access drops ready on the next cycle. Ready returns `GAP` edges later.
- R5: A data access to an endpoint other than the selected one, in the opposite direction, or during a zero-length request is ignored and sets the error bit.
- R6: A data access made while ready is 0 is ignored and sets the error bit. The error bit stays set until a control write with bit 7 at 1 clears it.
- R7: For a read request, ready also needs the FIFO to hold a byte. For a write request, ready also needs the FIFO to have room.
- R8: While `host_busy` is 1 with `host_pipe` equal to the selected endpoint, ready is 0. Ready returns `GAP` edges after the host releases the pipe.
- R9: A `host_done` pulse gives `usb_irq` = 1 for exactly the next cycle. It also loads `act_pipe` with `host_pipe`, which then holds until the next pulse.
- R10: A control write that clears the request while a ready zero-length request is pending sets `zlp_flags[ep]`. A `host_done` on that pipe clears the flag, but a set in the same cycle wins.
- R11: A control write that clears the request makes ready read 0 at once.
- R12: While `host_busy` is 1, `host_push` appends `host_wdata` to the FIFO of `host_pipe` (ignored when full), `host_pop` removes its head, and `host_rdata` shows that head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Processor register address |
| bus_wr | input | 1 | Processor write strobe |
| bus_rd | input | 1 | Processor read strobe (pops on accepted data read) |
| bus_wdata | input | 8 | Processor write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| host_busy | input | 1 | Host currently owns `host_pipe` |
| host_pipe | input | 2 | Pipe number used by the host |
| host_done | input | 1 | Host finished a transaction on `host_pipe` |
| host_push | input | 1 | Host appends a byte |
| host_pop | input | 1 | Host removes the head byte |
| host_wdata | input | 8 | Byte from the host side |
| host_rdata | output | 8 | Head byte of the host pipe's FIFO |
| zlp_flags | output | N_EP | Pending zero-length packet per endpoint |
| usb_irq | output | 1 | One-cycle transaction-done interrupt |
| act_pipe | output | 2 | Pipe number of the last completed transaction |

## Verification
Three events can fall in one cycle: the host releasing the selected pipe, a processor data read aimed at that pipe, and a host completion. The bench drives all three on the same clock. It expects the read to be refused with error, the interrupt and pipe number to appear on the next edge, and ready to rise only after a full settle window counted from the release. It also arms a zero-length packet in the same cycle that the host completes that pipe, and expects the flag to survive. Settle windows are swept by attempting an access at every offset from zero to `GAP-1`.

// File: rtl/epfifo_pkg.sv
// Package: shared control-word layout for the endpoint FIFO access controller.
// Assumes an endpoint field of two bits, so at most four endpoints.
package epfifo_pkg;

    localparam int EP_FIELD_W = 2;

    // Read-back image of the control register, most significant bit first.
    typedef struct packed {
        logic                  err;
        logic                  ready;
        logic [EP_FIELD_W-1:0] ep;
        logic                  rsv;
        logic                  zlp;
        logic                  dir;
        logic                  req;
    } ctl_word_t;

    localparam int BIT_REQ  = 0;
    localparam int BIT_DIR  = 1;
    localparam int BIT_ZLP  = 2;
    localparam int BIT_EP   = 4;
    localparam int BIT_ERRC = 7;

endpackage

// File: rtl/epfifo_ep_store.sv
// Module: one endpoint byte FIFO with a registered count.
// Push when full and pop when empty are dropped here, so callers may request
// freely. The head byte is visible combinationally. Assumes DEPTH is a power of two.
module epfifo_ep_store #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  logic [7:0] wdata,
    output logic [7:0] head,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    // Qualify requests against occupancy.
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    assign empty = (cnt == '0);
    assign full  = (cnt == FULL_CNT);
    assign head  = mem[rp];

    // Storage array write port, no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/epfifo_settle_timer.sv
// Module: settle-window counter.
// Restart forces the count to zero. While run is high the count climbs and
// saturates at GAP, and settled is high at saturation. Assumes GAP >= 1.
module epfifo_settle_timer #(
    parameter int GAP = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic settled
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] GAP_C = CW'(GAP);

    logic [CW-1:0] cnt;

    assign settled = (cnt == GAP_C);

    // Count cycles since the last restart, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (!settled) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/epfifo_pipe_events.sv
// Module: host completion events.
// Produces the one-cycle interrupt, latches the completed pipe number and keeps
// one pending zero-length flag per endpoint. A set wins over a clear in the same cycle.
module epfifo_pipe_events #(
    parameter int N_EP = 3,
    parameter int EPW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_done,
    input  logic [EPW-1:0]  host_pipe,
    input  logic            zlp_arm,
    input  logic [EPW-1:0]  arm_ep,
    output logic            usb_irq,
    output logic [EPW-1:0]  act_pipe,
    output logic [N_EP-1:0] zlp_flags
);
    // Interrupt pulse and completed-pipe latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usb_irq  <= 1'b0;
            act_pipe <= '0;
        end else begin
            usb_irq <= host_done;
            if (host_done) begin
                act_pipe <= host_pipe;
            end
        end
    end

    for (genvar i = 0; i < N_EP; i++) begin : g_zlp
        // Per-endpoint pending zero-length packet flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                zlp_flags[i] <= 1'b0;
            end else if (zlp_arm && arm_ep == EPW'(i)) begin
                zlp_flags[i] <= 1'b1;
            end else if (host_done && host_pipe == EPW'(i)) begin
                zlp_flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/epfifo_access_ctrl.sv
// Module: top of the endpoint FIFO access handshake controller.
// The processor selects an endpoint and direction through a control register,
// polls ready, then moves one byte per settle window through a data register.
// The host-active pipe is excluded from processor access. Assumes N_EP <= 4,
// GAP >= 1, and that the control and data addresses do not overlap.
module epfifo_access_ctrl
    import epfifo_pkg::*;
#(
    parameter int N_EP      = 3,
    parameter int DEPTH     = 8,
    parameter int GAP       = 100,
    parameter int ADDR_W    = 4,
    parameter int CTL_ADDR  = 0,
    parameter int DATA_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              host_busy,
    input  logic [1:0]        host_pipe,
    input  logic              host_done,
    input  logic              host_push,
    input  logic              host_pop,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [N_EP-1:0]   zlp_flags,
    output logic              usb_irq,
    output logic [1:0]        act_pipe
);
    localparam int EPW = EP_FIELD_W;
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
    localparam logic [EPW:0]      EP_LIMIT = (EPW+1)'(N_EP);

    // Control state.
    logic           req_q;
    logic           dir_q;
    logic           zlp_q;
    logic [EPW-1:0] ep_q;
    logic           err_q;

    // Decode and qualification.
    logic            ctl_hit;
    logic            ctl_write;
    logic [N_EP-1:0] addr_sel;
    logic            data_hit;
    logic            own_hit;
    logic            ep_valid;
    logic            conflict;
    logic            settled;
    logic            room_ok;
    logic            ready_w;
    logic            cpu_rd_ok;
    logic            cpu_wr_ok;
    logic            acc_ok;
    logic            bad_access;
    logic            zlp_arm;

    // Per-endpoint FIFO signals.
    logic [7:0]      head_v [N_EP];
    logic [N_EP-1:0] empty_v;
    logic [N_EP-1:0] full_v;
    logic [N_EP-1:0] push_v;
    logic [N_EP-1:0] pop_v;
    logic [7:0]      push_data;
    logic [7:0]      sel_head;
    logic            sel_empty;
    logic            sel_full;
    logic            host_pipe_ok;

    logic            unused_wbits;
    assign unused_wbits = &{1'b0, bus_wdata[6], bus_wdata[3]};

    assign ctl_hit   = (bus_addr == CTL_A);
    assign ctl_write = bus_wr && ctl_hit;
    assign ep_valid  = ({1'b0, ep_q} < EP_LIMIT);
    assign conflict  = host_busy && (host_pipe == ep_q);
    assign host_pipe_ok = ({1'b0, host_pipe} < EP_LIMIT);

    for (genvar i = 0; i < N_EP; i++) begin : g_dec
        assign addr_sel[i] = (bus_addr == ADDR_W'(DATA_BASE + i));
    end

    assign data_hit = |addr_sel;

    // Pick the selected endpoint's status and whether the bus hits its data register.
    always_comb begin
        own_hit   = 1'b0;
        sel_head  = '0;
        sel_empty = 1'b1;
        sel_full  = 1'b1;
        for (int i = 0; i < N_EP; i++) begin
            if (ep_q == EPW'(i)) begin
                own_hit   = addr_sel[i];
                sel_head  = head_v[i];
                sel_empty = empty_v[i];
                sel_full  = full_v[i];
            end
        end
    end

    // Data-availability condition for the pending request.
    always_comb begin
        if (zlp_q) begin
            room_ok = 1'b1;
        end else if (dir_q) begin
            room_ok = !sel_full;
        end else begin
            room_ok = !sel_empty;
        end
    end

    assign ready_w = req_q && ep_valid && settled && !conflict && room_ok;

    // Classify the processor data access of this cycle.
    always_comb begin
        cpu_rd_ok  = bus_rd && own_hit && ready_w && !zlp_q && !dir_q;
        cpu_wr_ok  = bus_wr && own_hit && ready_w && !zlp_q && dir_q;
        acc_ok     = cpu_rd_ok || cpu_wr_ok;
        bad_access = (bus_rd || bus_wr) && data_hit && !acc_ok;
        zlp_arm    = ctl_write && !bus_wdata[BIT_REQ] && req_q && zlp_q && ready_w;
    end

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            dir_q <= 1'b0;
            zlp_q <= 1'b0;
            ep_q  <= '0;
        end else if (ctl_write) begin
            req_q <= bus_wdata[BIT_REQ];
            dir_q <= bus_wdata[BIT_DIR];
            zlp_q <= bus_wdata[BIT_ZLP];
            ep_q  <= bus_wdata[BIT_EP +: EPW];
        end
    end

    // Sticky access error, cleared only by an explicit control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (ctl_write && bus_wdata[BIT_ERRC]) begin
            err_q <= 1'b0;
        end else if (bad_access) begin
            err_q <= 1'b1;
        end
    end

    epfifo_settle_timer #(
        .GAP (GAP)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctl_write || acc_ok || conflict),
        .run     (req_q),
        .settled (settled)
    );

    // Route processor or host requests to each FIFO; the two never share a pipe.
    always_comb begin
        push_data = cpu_wr_ok ? bus_wdata : host_wdata;
        for (int i = 0; i < N_EP; i++) begin
            push_v[i] = (cpu_wr_ok && ep_q == EPW'(i))
                     || (host_busy && host_push && host_pipe == EPW'(i));
            pop_v[i]  = (cpu_rd_ok && ep_q == EPW'(i))
                     || (host_busy && host_pop && host_pipe == EPW'(i));
        end
    end

    for (genvar i = 0; i < N_EP; i++) begin : g_ep
        epfifo_ep_store #(
            .DEPTH (DEPTH)
        ) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[i]),
            .pop   (pop_v[i]),
            .wdata (push_data),
            .head  (head_v[i]),
            .empty (empty_v[i]),
            .full  (full_v[i])
        );
    end

    // Host-side head byte of the pipe in use.
    always_comb begin
        host_rdata = '0;
        if (host_busy && host_pipe_ok) begin
            for (int i = 0; i < N_EP; i++) begin
                if (host_pipe == EPW'(i)) begin
                    host_rdata = head_v[i];
                end
            end
        end
    end

    // Register read mux: control image, or the head byte when a read would be accepted.
    always_comb begin
        ctl_word_t img;
        img.err   = err_q;
        img.ready = ready_w;
        img.ep    = ep_q;
        img.rsv   = 1'b0;
        img.zlp   = zlp_q;
        img.dir   = dir_q;
        img.req   = req_q;
        if (ctl_hit) begin
            bus_rdata = img;
        end else if (own_hit && ready_w && !dir_q && !zlp_q) begin
            bus_rdata = sel_head;
        end else begin
            bus_rdata = '0;
        end
    end

    epfifo_pipe_events #(
        .N_EP (N_EP),
        .EPW  (EPW)
    ) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_done (host_done),
        .host_pipe (host_pipe),
        .zlp_arm   (zlp_arm),
        .arm_ep    (ep_q),
        .usb_irq   (usb_irq),
        .act_pipe  (act_pipe),
        .zlp_flags (zlp_flags)
    );

endmodule

// File: rtl/epfifo_access_checker.sv
// Module: temporal checks for the access controller, bound into the top.
// Assumes a synchronous active-low reset held for at least one edge.
module epfifo_access_checker #(
    parameter int N_EP     = 3,
    parameter int ADDR_W   = 4,
    parameter int CTL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              host_done,
    input logic [1:0]        host_pipe,
    input logic              usb_irq,
    input logic [1:0]        act_pipe,
    input logic [N_EP-1:0]   zlp_flags,
    input logic              ready_w,
    input logic              acc_ok,
    input logic              err_q
);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

    assert_irq_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> usb_irq);

    assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_done |=> !usb_irq);

    assert_act_pipe_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> (act_pipe == $past(host_pipe)));

    assert_err_clear_only_by_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(bus_wr && bus_addr == CTL_A && bus_wdata[7]));

    assert_ready_drops_after_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |=> !ready_w);

    assert_zlp_set_by_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((zlp_flags & ~$past(zlp_flags)) != '0)
        |-> $past(bus_wr && bus_addr == CTL_A && !bus_wdata[0]));

endmodule

bind epfifo_access_ctrl epfifo_access_checker #(
    .N_EP     (N_EP),
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .host_done (host_done),
    .host_pipe (host_pipe),
    .usb_irq   (usb_irq),
    .act_pipe  (act_pipe),
    .zlp_flags (zlp_flags),
    .ready_w   (ready_w),
    .acc_ok    (acc_ok),
    .err_q     (err_q)
);

// File: tb/sim_epfifo_access_ctrl.sv
module sim_epfifo_access_ctrl;
    localparam int N_EP  = 3;
    localparam int DEPTH = 4;
    localparam int GAP   = 4;
    localparam int CTLA  = 0;
    localparam int DB    = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       host_busy = 1'b0;
    logic [1:0] host_pipe = '0;
    logic       host_done = 1'b0, host_push = 1'b0, host_pop = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [N_EP-1:0] zlp_flags;
    logic       usb_irq;
    logic [1:0] act_pipe;

    logic       hb = 1'b0;
    logic [1:0] hp = '0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    epfifo_access_ctrl #(
        .N_EP(N_EP), .DEPTH(DEPTH), .GAP(GAP), .ADDR_W(4), .CTL_ADDR(CTLA), .DATA_BASE(DB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_busy(host_busy),
        .host_pipe(host_pipe), .host_done(host_done), .host_push(host_push),
        .host_pop(host_pop), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .zlp_flags(zlp_flags), .usb_irq(usb_irq), .act_pipe(act_pipe)
    );

    task automatic check(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // One bus/host cycle: drive at the falling edge, sample, cross the rising edge.
    task automatic cyc(input logic w, input logic r, input int a, input logic [7:0] d,
                       input logic done, input logic push, input logic pop,
                       input logic [7:0] hd, output logic [7:0] rv, output logic [7:0] hv);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = 4'(a); bus_wdata = d;
        host_busy = hb; host_pipe = hp; host_done = done;
        host_push = push; host_pop = pop; host_wdata = hd;
        #1;
        rv = bus_rdata; hv = host_rdata;
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; host_done = 0; host_push = 0; host_pop = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ctl_wr(input logic [7:0] v);
        logic [7:0] a, b;
        cyc(1, 0, CTLA, v, 0, 0, 0, 0, a, b);
    endtask

    task automatic peek_ctl(output logic [7:0] v);
        bus_addr = 4'(CTLA);
        #1;
        v = bus_rdata;
    endtask

    task automatic dread(input int ep, output logic [7:0] v);
        logic [7:0] b;
        cyc(0, 1, DB + ep, 0, 0, 0, 0, 0, v, b);
    endtask

    task automatic dwrite(input int ep, input logic [7:0] d);
        logic [7:0] a, b;
        cyc(1, 0, DB + ep, d, 0, 0, 0, 0, a, b);
    endtask

    task automatic hpush(input logic [7:0] d);
        logic [7:0] a, b;
        cyc(0, 0, CTLA, 0, 0, 1, 0, d, a, b);
    endtask

    task automatic hpop(output logic [7:0] v);
        logic [7:0] a;
        cyc(0, 0, CTLA, 0, 0, 0, 1, 0, a, v);
    endtask

    task automatic hdone(input logic [1:0] p);
        logic [7:0] a, b;
        hp = p;
        cyc(0, 0, CTLA, 0, 1, 0, 0, 0, a, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, h;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        peek_ctl(v);
        check("R1 ctl", v, 8'h00);
        check("R1 irq", usb_irq, 0);
        check("R1 act", act_pipe, 0);
        check("R1 zlp", zlp_flags, 0);

        // Read direction on every endpoint: host fills, processor drains.
        for (int e = 0; e < N_EP; e++) begin
            hb = 1; hp = 2'(e);
            for (int i = 0; i <= DEPTH; i++) hpush(8'(e * 16 + i)); // last one dropped when full (R12)
            hb = 0;
            ctl_wr(8'(1 | (e << 4)));
            idle(GAP - 1);
            peek_ctl(v);
            check("R2 not yet ready", v, 1 | (e << 4));
            idle(1);
            peek_ctl(v);
            check("R2 ready at window", v, 8'h41 | (e << 4));
            for (int i = 0; i < DEPTH; i++) begin
                dread(e, v);
                check("R3 read order", v, e * 16 + i);
                idle(GAP - 1);
                peek_ctl(v);
                check("R4 ready low in window", v, 1 | (e << 4));
                idle(1);
                peek_ctl(v);
                if (i < DEPTH - 1) check("R4 ready back", v, 8'h41 | (e << 4));
                else check("R7 empty holds ready low", v, 1 | (e << 4));
            end
            ctl_wr(8'h00);
        end

        // Write direction on every endpoint: processor fills, host drains.
        for (int e = 0; e < N_EP; e++) begin
            ctl_wr(8'(3 | (e << 4)));
            idle(GAP);
            peek_ctl(v);
            check("R2 write ready", v, 8'h43 | (e << 4));
            for (int i = 0; i < DEPTH; i++) begin
                dwrite(e, 8'(8'hA0 + e * 16 + i));
                idle(GAP);
                peek_ctl(v);
                if (i < DEPTH - 1) check("R4 write ready back", v, 8'h43 | (e << 4));
                else check("R7 full holds ready low", v, 3 | (e << 4));
            end
            ctl_wr(8'h00);
            hb = 1; hp = 2'(e);
            for (int i = 0; i < DEPTH; i++) begin
                hpop(h);
                check("R12 host pop order", h, 8'hA0 + e * 16 + i);
            end
            hb = 0;
        end

        // Early-access sweep over every offset inside the window (ep1).
        hb = 1; hp = 2'd1;
        for (int i = 0; i < DEPTH; i++) hpush(8'(8'h50 + i));
        hb = 0;
        for (int j = 0; j < GAP; j++) begin
            ctl_wr(8'h91);
            peek_ctl(v);
            check("R6 clear by bit7", v, 8'h11);
            idle(j);
            dread(1, v);
            check("R6 early read dropped", v, 0);
            idle(GAP);
            peek_ctl(v);
            check("R6 error sticky", v, 8'hD1);
            ctl_wr(8'h91);
            idle(GAP);
            dread(1, v);
            check("R3 byte kept after early read", v, 8'h50 + j);
        end
        ctl_wr(8'h00);

        // Wrong endpoint and wrong direction.
        ctl_wr(8'h03);
        idle(GAP);
        dwrite(2, 8'h55);
        peek_ctl(v);
        check("R5 wrong endpoint", v, 8'hC3);
        ctl_wr(8'h83);
        idle(GAP);
        dread(0, v);
        check("R5 wrong direction data", v, 0);
        peek_ctl(v);
        check("R5 wrong direction err", v, 8'hC3);
        ctl_wr(8'h80);
        ctl_wr(8'h21);
        idle(GAP + 2);
        peek_ctl(v);
        check("R5 ep2 untouched", v, 8'h21);
        ctl_wr(8'h00);

        // Host owns the selected pipe; release, read and completion in one cycle.
        hb = 1; hp = 2'd1;
        hpush(8'h77);
        ctl_wr(8'h11);
        idle(GAP + 3);
        peek_ctl(v);
        check("R8 held during host use", v, 8'h11);
        hb = 0;
        cyc(0, 1, DB + 1, 0, 1, 0, 0, 0, v, h);
        check("R8 read on release cycle dropped", v, 0);
        check("R9 irq", usb_irq, 1);
        check("R9 act_pipe", act_pipe, 1);
        peek_ctl(v);
        check("R6 err after release read", v, 8'h91);
        idle(GAP - 2);
        peek_ctl(v);
        check("R8 window after release", v, 8'h91);
        check("R9 irq one cycle", usb_irq, 0);
        check("R9 act_pipe holds", act_pipe, 1);
        idle(1);
        peek_ctl(v);
        check("R8 ready after release", v, 8'hD1);
        ctl_wr(8'h91);
        idle(GAP);
        dread(1, v);
        check("R3 byte after release", v, 8'h77);
        ctl_wr(8'h00);

        // Zero-length packet commands.
        ctl_wr(8'h07);
        idle(GAP);
        peek_ctl(v);
        check("R10 zlp ready", v, 8'h47);
        hp = 2'd0;
        cyc(1, 0, CTLA, 8'h06, 1, 0, 0, 0, v, h);
        check("R10 set wins over done", zlp_flags, 3'b001);
        check("R9 act_pipe 0", act_pipe, 0);
        hdone(2'd0);
        check("R10 cleared by done", zlp_flags, 3'b000);
        ctl_wr(8'h27);
        ctl_wr(8'h26);
        check("R10 not armed when not ready", zlp_flags, 3'b000);
        ctl_wr(8'h17);
        idle(GAP);
        ctl_wr(8'h16);
        check("R10 ep1 armed", zlp_flags, 3'b010);
        hdone(2'd2);
        check("R10 other pipe keeps flag", zlp_flags, 3'b010);
        hdone(2'd1);
        check("R10 own pipe clears", zlp_flags, 3'b000);

        // Dropping the request.
        ctl_wr(8'h03);
        idle(GAP);
        peek_ctl(v);
        check("R11 ready before drop", v, 8'h43);
        ctl_wr(8'h02);
        peek_ctl(v);
        check("R11 ready gone at once", v, 8'h02);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule